// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

A clocked controller that sits between an on-chip requester and an external asynchronous static RAM of 128K words by 16 bits with two byte lanes. The requester issues one word access at a time over a valid/ready handshake, with a write flag, a 17-bit word address, write data and a two-bit byte-enable. Reads return through a one-cycle response pulse carrying the read word.

On the memory side the controller drives registered, glitch-free strobes: address, an active-low and an active-high chip select, write enable, output enable and two active-low byte strobes. It also drives a split data bus (value, drive enable, sampled input) for an external tristate pad. Every device timing limit is a parameter in picoseconds that is turned into a clock count. The controller waits out the supply settling time after reset and keeps the device in standby between accesses. It never drives the bus while the device may still be driving it.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, `req_ready_o` stays low and the chip is deselected for exactly PWR_CYC = ceil(T_PWRUP_PS / CLK_PS) cycles. During reset, all memory strobes are inactive and `mem_dq_oe_o` is 0.
- R2: Whenever `req_ready_o` is high the device is in standby: `mem_cs_no`=1, `mem_cs2_o`=0, `mem_we_no`=1, `mem_oe_no`=1, both byte strobes 1, `mem_dq_oe_o`=0.
- R3: A read holds `mem_cs_no`=0, `mem_cs2_o`=1, `mem_oe_no`=0 and `mem_we_no`=1 for exactly RD_CYC = max(ceil(T_RC), ceil(T_AA)) cycles, with `mem_dq_oe_o`=0 throughout. `req_be_i[0]` drives `mem_lb_no` low (bits 7:0) and `req_be_i[1]` drives `mem_ub_no` low (bits 15:8).
- R4: The data bus is sampled on the last cycle of the read. One cycle later `rsp_valid_o` pulses for a single cycle, and any byte lane that was not enabled reads as zero.
- R5: A write holds `mem_we_no`=0 for exactly WR_CYC = max(ceil(T_PWE), ceil(T_AW), ceil(T_SD)) cycles, with `mem_oe_no`=1, `mem_dq_oe_o`=1 and the write data on `mem_dq_o`. Only the enabled lanes are strobed.
- R6: After write enable rises, the address and data stay driven for REC_CYC = max(1, ceil(T_WC) - WR_CYC) more cycles, so `mem_dq_oe_o` is high for WR_CYC + REC_CYC cycles with a stable address.
- R7: `mem_dq_oe_o` never rises until output enable has been high for at least TA_CYC = ceil(T_HZ) cycles, and it is never high while `mem_oe_no` is low. Back-to-back writes add no turnaround.
- R8: A request with both byte enables clear completes with no chip select. A read of this kind returns a response of 0.
- R9: Every timing limit becomes a cycle count by rounding up with a minimum of one. The write pulse count covers the data setup time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 17 | Word address |
| req_wdata_i | input | 16 | Write data |
| req_be_i | input | 2 | Byte enables, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid_o | output | 1 | One-cycle read response pulse |
| rsp_rdata_o | output | 16 | Read data, disabled lanes zero |
| mem_addr_o | output | 17 | Memory address |
| mem_cs_no | output | 1 | Chip select, active low |
| mem_cs2_o | output | 1 | Second chip select, active high |
| mem_we_no | output | 1 | Write enable, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_ub_no | output | 1 | Upper byte strobe, active low |
| mem_lb_no | output | 1 | Lower byte strobe, active low |
| mem_dq_o | output | 16 | Data to pad |
| mem_dq_oe_o | output | 1 | Pad drive enable |
| mem_dq_i | input | 16 | Data from pad |

## Verification
Assertions check on every cycle that write enable and output enable are never both active, and that the pad drivers are off whenever output enable is low. They also check that each write-enable pulse lasts the full write count, that drivers only turn on after the output-disable wait, that the idle and power-up states keep the device deselected, and that responses are single pulses. Only the bench scenarios show that data lands in the right byte lanes and comes back zero-extended. The same holds for the read sampling instant against a memory model that returns valid data only after the access time, the exact read and recovery lengths, and the absence of any strobe for empty byte enables.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;
  localparam int unsigned DW = 16;
  localparam int unsigned NB = DW / 8;

  typedef enum logic [2:0] {
    ST_PWR, ST_IDLE, ST_TA, ST_RD, ST_WR, ST_REC, ST_NOP
  } st_e;

  function automatic int unsigned ps2cyc(input int unsigned ps, input int unsigned clk_ps);
    int unsigned c;
    c = (ps + clk_ps - 1) / clk_ps;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/asram_wait_cnt.sv
`timescale 1ns/1ps
module asram_wait_cnt #(
  parameter int unsigned W       = 8,
  parameter int unsigned RST_VAL = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= W'(RST_VAL);
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/asram_rd_fmt.sv
`timescale 1ns/1ps
module asram_rd_fmt
  import asram_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic [NB-1:0] be_i,
  input  logic [DW-1:0] din_i,
  output logic          valid_o,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mask;

  for (genvar l = 0; l < NB; l++) begin : g_lane
    assign mask[l*8 +: 8] = {8{be_i[l]}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      rdata_o <= '0;
    end else begin
      valid_o <= cap_i;
      if (cap_i) rdata_o <= din_i & mask;
    end
  end

  p_rsp_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
endmodule

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
module asram_seq
  import asram_pkg::*;
#(
  parameter int unsigned AW      = 17,
  parameter int unsigned RD_CYC  = 12,
  parameter int unsigned WR_CYC  = 9,
  parameter int unsigned REC_CYC = 3,
  parameter int unsigned TA_CYC  = 5,
  parameter int unsigned CW      = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pwr_done_i,
  input  logic          ta_done_i,
  output logic          ta_load_o,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_we_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic [NB-1:0] req_be_i,
  output logic          cap_o,
  output logic [NB-1:0] cap_be_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_cs_no,
  output logic          mem_cs2_o,
  output logic          mem_we_no,
  output logic          mem_oe_no,
  output logic [NB-1:0] mem_bs_no,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe_o
);
  st_e           st_q;
  logic [CW-1:0] cnt_q;
  logic [NB-1:0] be_q;
  logic          we_q;
  logic          last;

  assign last        = (cnt_q == '0);
  assign req_ready_o = (st_q == ST_IDLE);
  assign ta_load_o   = (st_q == ST_RD) && last;
  assign cap_o       = ((st_q == ST_RD) && last) || ((st_q == ST_NOP) && !we_q);
  assign cap_be_o    = be_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_PWR;
      cnt_q       <= '0;
      be_q        <= '0;
      we_q        <= 1'b0;
      mem_addr_o  <= '0;
      mem_cs_no   <= 1'b1;
      mem_cs2_o   <= 1'b0;
      mem_we_no   <= 1'b1;
      mem_oe_no   <= 1'b1;
      mem_bs_no   <= '1;
      mem_dq_o    <= '0;
      mem_dq_oe_o <= 1'b0;
    end else begin
      unique case (st_q)
        ST_PWR: if (pwr_done_i) st_q <= ST_IDLE;
        ST_IDLE: if (req_valid_i) begin
          mem_addr_o <= req_addr_i;
          mem_dq_o   <= req_wdata_i;
          be_q       <= req_be_i;
          we_q       <= req_we_i;
          if (req_be_i == '0) begin
            st_q <= ST_NOP;
          end else if (!req_we_i) begin
            st_q      <= ST_RD;
            cnt_q     <= CW'(RD_CYC - 1);
            mem_cs_no <= 1'b0;
            mem_cs2_o <= 1'b1;
            mem_oe_no <= 1'b0;
            mem_bs_no <= ~req_be_i;
          end else if (ta_done_i) begin
            st_q        <= ST_WR;
            cnt_q       <= CW'(WR_CYC - 1);
            mem_cs_no   <= 1'b0;
            mem_cs2_o   <= 1'b1;
            mem_we_no   <= 1'b0;
            mem_dq_oe_o <= 1'b1;
            mem_bs_no   <= ~req_be_i;
          end else begin
            st_q <= ST_TA;
          end
        end
        ST_TA: if (ta_done_i) begin
          st_q        <= ST_WR;
          cnt_q       <= CW'(WR_CYC - 1);
          mem_cs_no   <= 1'b0;
          mem_cs2_o   <= 1'b1;
          mem_we_no   <= 1'b0;
          mem_dq_oe_o <= 1'b1;
          mem_bs_no   <= ~be_q;
        end
        ST_RD: if (last) begin
          st_q      <= ST_IDLE;
          mem_cs_no <= 1'b1;
          mem_cs2_o <= 1'b0;
          mem_oe_no <= 1'b1;
          mem_bs_no <= '1;
        end else cnt_q <= cnt_q - 1'b1;
        ST_WR: if (last) begin
          // all write terms released on one edge; data held through recovery
          st_q      <= ST_REC;
          cnt_q     <= CW'(REC_CYC - 1);
          mem_we_no <= 1'b1;
          mem_cs_no <= 1'b1;
          mem_cs2_o <= 1'b0;
          mem_bs_no <= '1;
        end else cnt_q <= cnt_q - 1'b1;
        ST_REC: if (last) begin
          st_q        <= ST_IDLE;
          mem_dq_oe_o <= 1'b0;
        end else cnt_q <= cnt_q - 1'b1;
        ST_NOP: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // checker state
  logic [CW-1:0] we_lo_cnt;
  logic [CW-1:0] oe_hi_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_lo_cnt <= '0;
      oe_hi_cnt <= CW'(TA_CYC);
    end else begin
      we_lo_cnt <= mem_we_no ? '0 : we_lo_cnt + 1'b1;
      if (!mem_oe_no)                  oe_hi_cnt <= '0;
      else if (oe_hi_cnt < CW'(TA_CYC)) oe_hi_cnt <= oe_hi_cnt + 1'b1;
    end
  end

  p_oe_we_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> mem_oe_no);
  p_no_drive_oe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_no);
  p_ta_wait_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_dq_oe_o) |-> oe_hi_cnt >= CW'(TA_CYC));
  p_we_len_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> we_lo_cnt == CW'(WR_CYC));
  p_idle_stby_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> mem_cs_no && !mem_cs2_o && !mem_dq_oe_o && (mem_bs_no == '1));
  p_pwrup_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_done_i |-> mem_cs_no && !req_ready_o);
endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int unsigned AW          = 17,
  parameter int unsigned CLK_PS      = 4000,
  parameter int unsigned T_PWRUP_PS  = 200_000_000,
  parameter int unsigned T_WC_PS     = 45000,
  parameter int unsigned T_PWE_PS    = 35000,
  parameter int unsigned T_AW_PS     = 35000,
  parameter int unsigned T_SD_PS     = 25000,
  parameter int unsigned T_RC_PS     = 45000,
  parameter int unsigned T_AA_PS     = 45000,
  parameter int unsigned T_HZ_PS     = 18000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_we_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [15:0]   req_wdata_i,
  input  logic [1:0]    req_be_i,
  output logic          rsp_valid_o,
  output logic [15:0]   rsp_rdata_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_cs_no,
  output logic          mem_cs2_o,
  output logic          mem_we_no,
  output logic          mem_oe_no,
  output logic          mem_ub_no,
  output logic          mem_lb_no,
  output logic [15:0]   mem_dq_o,
  output logic          mem_dq_oe_o,
  input  logic [15:0]   mem_dq_i
);
  localparam int unsigned RD_CYC  = max2(ps2cyc(T_RC_PS, CLK_PS), ps2cyc(T_AA_PS, CLK_PS));
  // write pulse covers pulse width, address window and data setup
  localparam int unsigned WR_CYC  = max2(max2(ps2cyc(T_PWE_PS, CLK_PS), ps2cyc(T_AW_PS, CLK_PS)),
                                         ps2cyc(T_SD_PS, CLK_PS));
  localparam int unsigned WC_CYC  = ps2cyc(T_WC_PS, CLK_PS);
  localparam int unsigned REC_CYC = (WC_CYC > WR_CYC + 1) ? WC_CYC - WR_CYC : 1;
  localparam int unsigned TA_CYC  = ps2cyc(T_HZ_PS, CLK_PS);
  localparam int unsigned PWR_CYC = ps2cyc(T_PWRUP_PS, CLK_PS);
  localparam int unsigned MAXC    = max2(max2(RD_CYC, WR_CYC), max2(REC_CYC, TA_CYC));
  localparam int unsigned CW      = $clog2(MAXC + 1);
  localparam int unsigned PW      = $clog2(PWR_CYC + 1);
  localparam int unsigned TW      = $clog2(TA_CYC + 1);

  logic          pwr_done, ta_done, ta_load, cap;
  logic [NB-1:0] cap_be, bs_n;

  asram_wait_cnt #(.W(PW), .RST_VAL(PWR_CYC - 1)) u_pwr (
    .clk_i, .rst_ni, .load_i(1'b0), .val_i('0), .done_o(pwr_done)
  );

  asram_wait_cnt #(.W(TW), .RST_VAL(0)) u_ta (
    .clk_i, .rst_ni, .load_i(ta_load), .val_i(TW'(TA_CYC - 1)), .done_o(ta_done)
  );

  asram_seq #(
    .AW(AW), .RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .REC_CYC(REC_CYC),
    .TA_CYC(TA_CYC), .CW(CW)
  ) u_seq (
    .clk_i, .rst_ni,
    .pwr_done_i(pwr_done), .ta_done_i(ta_done), .ta_load_o(ta_load),
    .req_valid_i, .req_ready_o, .req_we_i, .req_addr_i, .req_wdata_i, .req_be_i,
    .cap_o(cap), .cap_be_o(cap_be),
    .mem_addr_o, .mem_cs_no, .mem_cs2_o, .mem_we_no, .mem_oe_no,
    .mem_bs_no(bs_n), .mem_dq_o, .mem_dq_oe_o
  );

  assign mem_lb_no = bs_n[0];
  assign mem_ub_no = bs_n[1];

  asram_rd_fmt u_fmt (
    .clk_i, .rst_ni, .cap_i(cap), .be_i(cap_be), .din_i(mem_dq_i),
    .valid_o(rsp_valid_o), .rdata_o(rsp_rdata_o)
  );
endmodule

// File: tb/asram_ctrl_bench.sv
`timescale 1ns/1ps
module asram_ctrl_bench;
  localparam int CLK_PS  = 4000;
  localparam int PWR_PS  = 400_000;
  function automatic int cdiv(input int ps);
    int c;
    c = (ps + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : c;
  endfunction
  localparam int RD_CYC  = cdiv(45000);
  localparam int WR_CYC  = cdiv(35000);
  localparam int REC_CYC = cdiv(45000) - WR_CYC;
  localparam int TA_CYC  = cdiv(18000);
  localparam int PWR_CYC = cdiv(PWR_PS);

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [16:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [16:0] mem_addr;
  logic        cs_n, cs2, we_n, oe_n, ub_n, lb_n, dq_oe;
  logic [15:0] dq_o, dq_i;

  asram_ctrl #(.T_PWRUP_PS(PWR_PS)) u_asram_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_be_i(req_be),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .mem_addr_o(mem_addr), .mem_cs_no(cs_n), .mem_cs2_o(cs2), .mem_we_no(we_n),
    .mem_oe_no(oe_n), .mem_ub_no(ub_n), .mem_lb_no(lb_n),
    .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
    end
  endtask

  // memory model and shadow
  logic [15:0] model [int];
  logic [15:0] shadow [int];
  logic [15:0] exp_q [$];
  int rd_run = 0;

  function automatic logic [15:0] mrd(input int a);
    return model.exists(a) ? model[a] : 16'h0000;
  endfunction
  function automatic logic [15:0] srd(input int a);
    return shadow.exists(a) ? shadow[a] : 16'h0000;
  endfunction

  logic [15:0] mword;
  always_comb begin
    mword = mrd(int'(mem_addr));
    if (lb_n) mword[7:0]  = 8'h5A;
    if (ub_n) mword[15:8] = 8'h5A;
  end
  assign dq_i = (rd_run >= RD_CYC) ? mword : 16'hBAD0;

  // monitor
  int we_run = 0, oe_run = 0, dq_run = 0, dq_gap = 0, last_gap = 0, oe_hi = 0, cs_lo = 0;
  logic [16:0] addr0;
  bit addr_moved, rd_bad;
  logic prev_ready = 1'b0, prev_dq_oe = 1'b0;

  always @(negedge clk) if (rst_n) begin
    if (!cs_n && cs2 && !we_n) begin
      logic [15:0] w;
      w = mrd(int'(mem_addr));
      if (!lb_n) w[7:0]  = dq_o[7:0];
      if (!ub_n) w[15:8] = dq_o[15:8];
      model[int'(mem_addr)] = w;
      chk(dq_oe && oe_n, "R5", "write drive/oe", {dq_oe, oe_n}, 2'b11);
    end
    if (!we_n) we_run++;
    else if (we_run != 0) begin
      chk(we_run == WR_CYC, "R5", "R9 we pulse cycles", we_run, WR_CYC);
      we_run = 0;
    end
    if (!oe_n) begin
      oe_run++;
      if (!(we_n && !dq_oe && cs2 && !cs_n)) rd_bad = 1;
    end else if (oe_run != 0) begin
      chk(oe_run == RD_CYC, "R3", "read oe cycles", oe_run, RD_CYC);
      chk(!rd_bad, "R3", "read strobes", rd_bad, 0);
      oe_run = 0; rd_bad = 0;
    end
    if (dq_oe && !prev_dq_oe) begin
      chk(oe_hi >= TA_CYC, "R7", "turnaround", oe_hi, TA_CYC);
      last_gap = dq_gap;
      addr0 = mem_addr; addr_moved = 0;
    end
    if (dq_oe) begin
      dq_run++; dq_gap = 0;
      if (mem_addr != addr0) addr_moved = 1;
      chk(oe_n, "R7", "drive with oe low", oe_n, 1);
    end else begin
      dq_gap++;
      if (dq_run != 0) begin
        chk(dq_run == WR_CYC + REC_CYC, "R6", "drive cycles", dq_run, WR_CYC + REC_CYC);
        chk(!addr_moved, "R6", "addr stable", addr_moved, 0);
        dq_run = 0;
      end
    end
    oe_hi = oe_n ? oe_hi + 1 : 0;
    if (!cs_n) cs_lo++;
    if (req_ready && !prev_ready)
      chk(cs_n && !cs2 && we_n && oe_n && ub_n && lb_n && !dq_oe, "R2", "standby",
          {cs_n, cs2, we_n, oe_n, ub_n, lb_n, dq_oe}, 7'b1011110);
    if (rsp_valid) begin
      if (exp_q.size() == 0) chk(0, "R4", "unexpected rsp", rsp_rdata, 0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(rsp_rdata == e, "R4", "read data", rsp_rdata, e);
      end
    end
    rd_run = (!cs_n && cs2 && !oe_n && we_n) ? rd_run + 1 : 0;
    prev_ready = req_ready;
    prev_dq_oe = dq_oe;
  end

  task automatic do_req(input logic we, input logic [16:0] a,
                        input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
    if (we) begin
      logic [15:0] s;
      s = srd(int'(a));
      if (be[0]) s[7:0]  = d[7:0];
      if (be[1]) s[15:8] = d[15:8];
      if (be != 2'b00) shadow[int'(a)] = s;
    end else begin
      logic [15:0] s;
      s = srd(int'(a));
      exp_q.push_back({be[1] ? s[15:8] : 8'h00, be[0] ? s[7:0] : 8'h00});
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (!req_ready || exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int n, cs0;
    repeat (3) @(negedge clk);
    chk(!req_ready && cs_n && we_n && oe_n && !dq_oe, "R1", "reset state",
        {req_ready, cs_n, we_n, oe_n, dq_oe}, 5'b01110);
    rst_n = 1'b1;
    n = 0;
    while (!req_ready && n < 1000) begin @(negedge clk); n++; end
    chk(n == PWR_CYC, "R1", "power-up cycles", n, PWR_CYC);

    do_req(1, 17'h00010, 16'hA55A, 2'b11);
    do_req(0, 17'h00010, 16'h0000, 2'b11);
    do_req(1, 17'h00010, 16'h1234, 2'b01);   // lower lane only
    do_req(0, 17'h00010, 16'h0000, 2'b11);
    do_req(0, 17'h00010, 16'h0000, 2'b01);   // R4 zero-extend upper
    do_req(0, 17'h00010, 16'h0000, 2'b10);   // R4 zero-extend lower
    do_req(1, 17'h1FFFF, 16'hFFFF, 2'b11);
    do_req(1, 17'h00020, 16'hBEEF, 2'b10);   // upper lane only
    do_req(0, 17'h1FFFF, 16'h0000, 2'b11);
    do_req(0, 17'h00020, 16'h0000, 2'b11);
    drain();

    // R7 read followed at once by a write
    do_req(0, 17'h00010, 16'h0000, 2'b11);
    do_req(1, 17'h00030, 16'hC3C3, 2'b11);
    drain();
    // R7 back-to-back writes: no turnaround gap
    do_req(1, 17'h00040, 16'h1111, 2'b11);
    do_req(1, 17'h00041, 16'h2222, 2'b11);
    drain();
    chk(last_gap <= 2, "R7", "write-write gap", last_gap, 2);
    do_req(0, 17'h00041, 16'h0000, 2'b11);
    do_req(0, 17'h00030, 16'h0000, 2'b11);
    drain();

    // R8 empty byte enables
    cs0 = cs_lo;
    do_req(1, 17'h00040, 16'hDEAD, 2'b00);
    do_req(0, 17'h00040, 16'h0000, 2'b00);
    drain();
    chk(cs_lo == cs0, "R8", "no chip select", cs_lo - cs0, 0);
    do_req(0, 17'h00040, 16'h0000, 2'b11);
    drain();

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog act=0 exp=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule